// File: doc/BRIEF.md
# Oversampling UART Receive Recovery

This block is the receive front end of an asynchronous serial port. A tick input that runs at sixteen times the bit rate enables all of its state. On each tick the block samples a serial line that has already been synchronised to the clock. It searches for a start bit and checks it with a vote of three early samples. It then recovers eight data bits, least significant first, each by a majority of three mid-bit samples, and reads one stop bit the same way. The bit-phase counter is realigned whenever a bit that voted one is followed by a falling line edge, so the receiver can follow a sender whose rate differs from its own.

When the stop bit has been voted, the assembled byte moves into a receive buffer and a data-ready flag is set. The buffer also carries a noise flag and a framing-error flag for that frame. A read strobe empties the buffer. If a frame ends while the buffer is still full, an overrun flag is set instead of overwriting the buffer. The interrupt request is the data-ready flag gated by an enable input.

Top module: `uart_rx_recover`

## Requirements
- R1: All receiver state advances only in clock cycles where `tick16` is high. The line value in cycles without a tick has no effect on any output.
- R2: In the start search, a low sample that directly follows at least three consecutive high samples is taken as the start edge and counts as phase RT1. A low sample after fewer than three highs is ignored.
- R3: The start bit is voted on the samples at RT3, RT5 and RT7. No high sample accepts the start bit cleanly. Exactly one high sample accepts it and marks the frame noisy. Two or more high samples reject it, and the receiver returns to the start search without touching the buffer.
- R4: Each bit occupies 16 ticks (RT1..RT16) after the start bit. Its value is the majority of the samples at RT8, RT9 and RT10. Eight data bits arrive LSB first, and bit 0 of `rxData` is the first data bit.
- R5: If the three mid-bit samples of any data or stop bit disagree, or the start vote saw exactly one high, `noiseFlag` is 1 for that frame.
- R6: A stop bit whose majority is 0 sets `frameErr` for that frame. A stop bit whose majority is 1 clears it.
- R7: At the RT10 tick of the stop bit, the byte and its flags are loaded into the buffer, and `dataFull` is 1 from the next cycle. After reset `dataFull` is 0.
- R8: `irqReq` is high exactly when `dataFull` and `irqEnable` are both high.
- R9: `readStrobe` clears `dataFull` and `overrun`. A frame that completes while `dataFull` is 1 and no read is present sets `overrun` and leaves `rxData`, `noiseFlag` and `frameErr` unchanged.
- R10: Once a data bit has voted 1 (and is not the last data bit), a one-to-zero line edge seen between its RT13 and the next bit's RT6 restarts the phase at RT1 of the next bit.
- R11: After a frame ends or a start bit is rejected, three new consecutive high samples are needed before a start edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Synchronised serial line |
| tick16 | input | 1 | Sample enable at 16x bit rate |
| readStrobe | input | 1 | Buffer read, empties the buffer |
| irqEnable | input | 1 | Interrupt request enable |
| rxData | output | 8 | Receive buffer |
| dataFull | output | 1 | Buffer holds an unread byte |
| noiseFlag | output | 1 | Noise seen in the buffered frame |
| frameErr | output | 1 | Stop bit of the buffered frame was low |
| overrun | output | 1 | A frame was lost while the buffer was full |
| irqReq | output | 1 | Interrupt request |

## Verification
The embedded assertions check every cycle that the phase is frozen between ticks, that the bit index stays within a frame, that the buffer fills only on a frame-completion strobe, and that a read empties it, a frame landing on a full buffer leaves it intact, and the framing flag changes only at completion. Other behaviours can only be shown by the bench scenarios, because they depend on what the line does over whole bit times. These are the start-vote outcomes, majority recovery with injected glitches, phase tracking for senders 12 percent fast and slow, and the need for three idle samples after a short stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rxState_t;

  typedef struct packed {
    logic shiftEn;     // push a recovered data bit
    logic shiftBit;    // value of that bit
    logic frameDone;   // stop bit voted
    logic frameNoise;  // accumulated noise for the frame
    logic stopBad;     // stop bit voted low
  } rxStrobes_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       lineIn,
  output rxStrobes_t strb
);

  localparam int BIT_W = $clog2(DATA_BITS + 1);
  localparam logic [BIT_W-1:0] STOP_IDX  = BIT_W'(DATA_BITS);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(DATA_BITS - 1);
  // phase encodes RTn as n-1
  localparam logic [3:0] PH_RT3  = 4'd2;
  localparam logic [3:0] PH_RT5  = 4'd4;
  localparam logic [3:0] PH_RT7  = 4'd6;
  localparam logic [3:0] PH_RT8  = 4'd7;
  localparam logic [3:0] PH_RT9  = 4'd8;
  localparam logic [3:0] PH_RT10 = 4'd9;
  localparam logic [3:0] WIN_LATE  = 4'd12;
  localparam logic [3:0] WIN_EARLY = 4'd5;

  rxState_t         state;
  logic [3:0]       phase;
  logic [3:0]       nextPh;
  logic [1:0]       onesCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             armed;
  logic             lastSample;
  logic             vote3, vote5;
  logic             mid8, mid9;
  logic             accNoise;
  logic [1:0]       voteCnt;
  logic             majority;
  logic             disagree;
  logic             fallEdge;
  logic             inWindow;
  logic             resync;
  logic             midPoint;

  always_comb begin
    nextPh   = phase + 4'd1;
    fallEdge = lastSample & ~lineIn;
    inWindow = (nextPh >= WIN_LATE) || (nextPh <= WIN_EARLY);
    resync   = tick16 && (state == RX_DATA) && armed && fallEdge && inWindow;
    voteCnt  = {1'b0, vote3} + {1'b0, vote5} + {1'b0, lineIn};
    majority = (mid8 & mid9) | (mid8 & lineIn) | (mid9 & lineIn);
    disagree = !((mid8 == mid9) && (mid9 == lineIn));
    midPoint = tick16 && (state == RX_DATA) && !resync && (nextPh == PH_RT10);
    strb.shiftEn    = midPoint && (bitIdx != STOP_IDX);
    strb.shiftBit   = majority;
    strb.frameDone  = midPoint && (bitIdx == STOP_IDX);
    strb.frameNoise = accNoise | disagree;
    strb.stopBad    = ~majority;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      phase      <= '0;
      onesCnt    <= '0;
      bitIdx     <= '0;
      armed      <= 1'b0;
      lastSample <= 1'b0;
      vote3      <= 1'b0;
      vote5      <= 1'b0;
      mid8       <= 1'b0;
      mid9       <= 1'b0;
      accNoise   <= 1'b0;
    end else if (tick16) begin
      lastSample <= lineIn;
      unique case (state)
        RX_IDLE: begin
          if (lineIn) begin
            onesCnt <= (onesCnt == 2'd3) ? 2'd3 : onesCnt + 2'd1;
          end else if (onesCnt == 2'd3) begin
            state   <= RX_START;
            phase   <= '0;
            onesCnt <= '0;
          end else begin
            onesCnt <= '0;
          end
        end
        RX_START: begin
          phase <= nextPh;
          if (nextPh == PH_RT3) vote3 <= lineIn;
          if (nextPh == PH_RT5) vote5 <= lineIn;
          if (nextPh == PH_RT7) begin
            if (voteCnt >= 2'd2) begin
              state   <= RX_IDLE;
              onesCnt <= '0;
            end else begin
              accNoise <= (voteCnt != 2'd0);
            end
          end
          if (nextPh == 4'd0) begin
            state  <= RX_DATA;
            bitIdx <= '0;
            armed  <= 1'b0;
          end
        end
        RX_DATA: begin
          if (resync) begin
            phase <= '0;
            armed <= 1'b0;
            if ((nextPh >= WIN_LATE) || (nextPh == 4'd0)) bitIdx <= bitIdx + 1'b1;
          end else begin
            phase <= nextPh;
            if (nextPh == 4'd0)   bitIdx <= bitIdx + 1'b1;
            if (nextPh == PH_RT7) armed  <= 1'b0;
            if (nextPh == PH_RT8) mid8   <= lineIn;
            if (nextPh == PH_RT9) mid9   <= lineIn;
            if (nextPh == PH_RT10) begin
              if (bitIdx == STOP_IDX) begin
                state   <= RX_IDLE;
                onesCnt <= '0;
              end else begin
                accNoise <= accNoise | disagree;
                armed    <= majority && (bitIdx < LAST_DATA);
              end
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R1
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(phase));

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitIdx <= STOP_IDX);

endmodule

// File: rtl/uart_rx_data.sv
module uart_rx_data
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 readStrobe,
  input  rxStrobes_t           strb,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataFull,
  output logic                 noiseFlag,
  output logic                 frameErr,
  output logic                 overrun
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 roomFree;

  assign roomFree = !dataFull || readStrobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      rxData    <= '0;
      dataFull  <= 1'b0;
      noiseFlag <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strb.shiftEn) shiftReg <= {strb.shiftBit, shiftReg[DATA_BITS-1:1]};
      if (readStrobe) begin
        dataFull <= 1'b0;
        overrun  <= 1'b0;
      end
      if (strb.frameDone) begin
        if (roomFree) begin
          rxData    <= shiftReg;
          dataFull  <= 1'b1;
          noiseFlag <= strb.frameNoise;
          frameErr  <= strb.stopBad;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

  // R7
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataFull) |-> $past(strb.frameDone));

  // R9
  buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.frameDone && dataFull && !readStrobe) |=> ($stable(rxData) && overrun));

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readStrobe && !strb.frameDone) |=> (!dataFull && !overrun));

  // R6
  ferr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frameErr) |-> $past(strb.frameDone));

endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lineIn,
  input  logic                 tick16,
  input  logic                 readStrobe,
  input  logic                 irqEnable,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataFull,
  output logic                 noiseFlag,
  output logic                 frameErr,
  output logic                 overrun,
  output logic                 irqReq
);

  rxStrobes_t strb;

  uart_rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick16 (tick16),
    .lineIn (lineIn),
    .strb   (strb)
  );

  uart_rx_data #(.DATA_BITS(DATA_BITS)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .readStrobe (readStrobe),
    .strb       (strb),
    .rxData     (rxData),
    .dataFull   (dataFull),
    .noiseFlag  (noiseFlag),
    .frameErr   (frameErr),
    .overrun    (overrun)
  );

  assign irqReq = dataFull & irqEnable;

endmodule

// File: tb/uart_rx_recover_test.sv
`timescale 1ns/1ps
module uart_rx_recover_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lineIn = 1'b1;
  logic       tick16 = 1'b0;
  logic       readStrobe = 1'b0;
  logic       irqEnable = 1'b0;
  logic [7:0] rxData;
  logic       dataFull, noiseFlag, frameErr, overrun, irqReq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_recover uut (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .tick16(tick16),
    .readStrobe(readStrobe), .irqEnable(irqEnable), .rxData(rxData),
    .dataFull(dataFull), .noiseFlag(noiseFlag), .frameErr(frameErr),
    .overrun(overrun), .irqReq(irqReq)
  );

  // behavioural reference: 0 search, 1 start vote, 2 bits
  int mSt, mOnes, mPh, mBit, mArm, mLast, mV3, mV5, mM8, mM9, mAcc;
  int mShift, mData, mFull, mNoise, mFerr, mOvr;

  always @(posedge clk) begin : refModel
    int s, np, votes, maj, dis, dn, db, oldFull;
    bit done;
    if (!rst_n) begin
      mSt = 0; mOnes = 0; mPh = 0; mBit = 0; mArm = 0; mLast = 0;
      mV3 = 0; mV5 = 0; mM8 = 0; mM9 = 0; mAcc = 0;
      mShift = 0; mData = 0; mFull = 0; mNoise = 0; mFerr = 0; mOvr = 0;
    end else begin
      done = 0; dn = 0; db = 0;
      if (tick16) begin
        s  = int'(lineIn);
        np = (mPh + 1) % 16;
        if (mSt == 0) begin
          if (s == 1) begin
            if (mOnes < 3) mOnes++;
          end else if (mOnes == 3) begin
            mSt = 1; mPh = 0; mOnes = 0;
          end else mOnes = 0;
        end else if (mSt == 1) begin
          mPh = np;
          if (np == 2) mV3 = s;
          if (np == 4) mV5 = s;
          if (np == 6) begin
            votes = mV3 + mV5 + s;
            if (votes >= 2) begin mSt = 0; mOnes = 0; end
            else mAcc = (votes != 0) ? 1 : 0;
          end
          if (np == 0) begin mSt = 2; mBit = 0; mArm = 0; end
        end else begin
          if (mArm == 1 && mLast == 1 && s == 0 && (np >= 12 || np <= 5)) begin
            mPh = 0; mArm = 0;
            if (np >= 12 || np == 0) mBit++;
          end else begin
            mPh = np;
            if (np == 0) mBit++;
            if (np == 6) mArm = 0;
            if (np == 7) mM8 = s;
            if (np == 8) mM9 = s;
            if (np == 9) begin
              maj = ((mM8 + mM9 + s) >= 2) ? 1 : 0;
              dis = (mM8 == mM9 && mM9 == s) ? 0 : 1;
              if (mBit == 8) begin
                done = 1; dn = mAcc | dis; db = 1 - maj;
                mSt = 0; mOnes = 0;
              end else begin
                mShift = (mShift >> 1) | (maj << 7);
                mAcc = mAcc | dis;
                mArm = (maj == 1 && mBit < 7) ? 1 : 0;
              end
            end
          end
        end
        mLast = s;
      end
      oldFull = mFull;
      if (readStrobe) begin mFull = 0; mOvr = 0; end
      if (done) begin
        if (oldFull == 0 || readStrobe) begin
          mData = mShift; mFull = 1; mNoise = dn; mFerr = db;
        end else mOvr = 1;
      end
    end
  end

  task automatic cmp(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!finished) begin
      cmp(int'(rxData),    mData,  "R4 rxData vs model");
      cmp(int'(dataFull),  mFull,  "R7 dataFull vs model");
      cmp(int'(noiseFlag), mNoise, "R5 noiseFlag vs model");
      cmp(int'(frameErr),  mFerr,  "R6 frameErr vs model");
      cmp(int'(overrun),   mOvr,   "R9 overrun vs model");
      cmp(int'(irqReq),    mFull & int'(irqEnable), "R8 irqReq vs model");
    end
  end

  // one tick with the given line value; garbage in the two idle cycles (R1)
  task automatic sendTick(input logic v);
    @(negedge clk); lineIn = v; tick16 = 1'b1;
    @(negedge clk); tick16 = 1'b0; lineIn = 1'($urandom & 1);
    @(negedge clk); lineIn = 1'($urandom & 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendTick(1'b1);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int bitLen, input logic stopV,
                           input int stopLen, input int flipA, input int flipB);
    int k = 0;
    logic v;
    for (int b = 0; b < 9; b++) begin
      for (int t = 0; t < bitLen; t++) begin
        v = (b == 0) ? 1'b0 : d[b-1];
        if (k == flipA || k == flipB) v = ~v;
        sendTick(v);
        k++;
      end
    end
    for (int t = 0; t < stopLen; t++) begin
      v = stopV;
      if (k == flipA || k == flipB) v = ~v;
      sendTick(v);
      k++;
    end
  endtask

  task automatic doRead();
    @(negedge clk); readStrobe = 1'b1;
    @(negedge clk); readStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (4) @(negedge clk);
    // reset state (R7, R8)
    cmp(int'(dataFull), 0, "R7 reset dataFull");
    cmp(int'(irqReq),   0, "R8 reset irqReq");
    rst_n = 1'b1;
    irqEnable = 1'b1;

    idle(4);
    sendFrame(8'hA5, 16, 1'b1, 16, -1, -1);
    idle(4);
    cmp(int'(rxData),    'hA5, "R4 clean byte");
    cmp(int'(dataFull),  1,    "R7 full after frame");
    cmp(int'(noiseFlag), 0,    "R5 clean frame noise");
    cmp(int'(frameErr),  0,    "R6 good stop");
    cmp(int'(irqReq),    1,    "R8 irq with enable");
    doRead();
    cmp(int'(dataFull),  0,    "R9 read clears full");

    // fast sender, 14 ticks per bit
    idle(4);
    sendFrame(8'h55, 14, 1'b1, 16, -1, -1);
    idle(4);
    cmp(int'(rxData), 'h55, "R10 fast sender tracked");
    doRead();
    // slow sender, 18 ticks per bit
    idle(4);
    sendFrame(8'h55, 18, 1'b1, 18, -1, -1);
    idle(4);
    cmp(int'(rxData), 'h55, "R10 slow sender tracked");
    doRead();
    idle(4);
    sendFrame(8'hA5, 15, 1'b1, 16, -1, -1);
    idle(4);
    doRead();
    idle(4);
    sendFrame(8'hA5, 17, 1'b1, 17, -1, -1);
    idle(4);
    doRead();

    // mid-bit glitch on data bit 0, RT9
    idle(4);
    sendFrame(8'h96, 16, 1'b1, 16, 24, -1);
    idle(4);
    cmp(int'(rxData),    'h96, "R4 majority outvotes glitch");
    cmp(int'(noiseFlag), 1,    "R5 mid-bit disagreement");
    doRead();

    // start vote pattern 010
    idle(4);
    sendFrame(8'hC3, 16, 1'b1, 16, 4, -1);
    idle(4);
    cmp(int'(rxData),    'hC3, "R3 noisy start accepted");
    cmp(int'(noiseFlag), 1,    "R3 one-high start vote noise");
    doRead();

    // start vote 011: rejected glitch
    idle(4);
    sendTick(1'b0); sendTick(1'b0); sendTick(1'b0);
    idle(40);
    cmp(int'(dataFull), 0,    "R3 rejected start loads nothing");
    cmp(int'(rxData),   'hC3, "R3 buffer untouched after reject");

    // framing error
    sendFrame(8'h3C, 16, 1'b0, 16, -1, -1);
    idle(4);
    cmp(int'(rxData),   'h3C, "R6 byte with bad stop");
    cmp(int'(frameErr), 1,    "R6 low stop flagged");
    doRead();

    // overrun
    idle(4);
    sendFrame(8'h0F, 16, 1'b1, 16, -1, -1);
    idle(4);
    cmp(int'(frameErr), 0, "R6 good stop clears flag");
    sendFrame(8'hF0, 16, 1'b1, 16, -1, -1);
    idle(4);
    cmp(int'(overrun),  1,    "R9 overrun set");
    cmp(int'(rxData),   'h0F, "R9 buffer kept on overrun");
    irqEnable = 1'b0;
    @(negedge clk);
    cmp(int'(irqReq),   0,    "R8 irq masked");
    doRead();
    cmp(int'(overrun),  0,    "R9 read clears overrun");
    cmp(int'(dataFull), 0,    "R9 read clears full after overrun");

    // short stop then only two highs before the next low
    irqEnable = 1'b1;
    idle(4);
    sendFrame(8'h81, 16, 1'b1, 11, -1, -1);
    doRead();
    sendTick(1'b1);
    sendFrame(8'hFF, 16, 1'b1, 16, -1, -1);
    idle(4);
    cmp(int'(dataFull), 0,    "R11 start needs three highs");
    cmp(int'(rxData),   'h81, "R2 low after two highs ignored");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule